// File: doc/BRIEF.md
# Paced Parallel Input Capture Controller

This block takes a parallel data word from outside the chip and writes it into a small receive queue. The host reads the queue through a pop port. A capture happens on one of three events. In pacer mode it is a one-cycle tick from an on-chip pacer: the fast tick, every second fast tick, or a tick from a programmable timer channel. In strobe mode it is an edge of an external request line, and software chooses whether that is the rising or the falling edge. In handshake mode it is a request/acknowledge exchange with the outside device.

A run-control machine decides when captures may start. It has three states. `RS_OFF` goes to `RS_RUN` on enable when the immediate start mode is selected, or to `RS_ARMED` on enable when the wait-for-trigger start mode is selected. `RS_ARMED` goes to `RS_RUN` once the trigger line reads active. Clearing the enable takes either state back to `RS_OFF`. The handshake machine has two states. `HS_IDLE` captures a word and moves to `HS_ACK` when it sees an active request while running. `HS_ACK` holds acknowledge active and returns to `HS_IDLE` when the request goes inactive or when the block stops running.

The request and trigger lines pass through a two-flop synchronizer, and their polarity is corrected after the synchronizer. Each of request, acknowledge and trigger has its own polarity select, where 1 means active-low. The width select keeps 8 (code 0), 16 (code 1) or 32 (codes 2 and 3) low bits of the input word and zeroes the rest. A live full flag is provided, and a separate sticky overrun flag records samples that were lost.

Top module: `pcap_ctrl`

## Requirements
- R1: After reset the queue is empty (`rd_valid`=0), `sts_full`=0, `sts_overrun`=0, and `ack_out` sits at its inactive level, which equals `pol_ack`.
- R2: With `cfg_clk_mode`=0 one word is captured per selected tick. `cfg_pace_sel`=0 uses each `tick_fast` pulse. `cfg_pace_sel`=1 uses every second `tick_fast` pulse counted from entry into `RS_RUN`, so the first capture is on the second pulse. `cfg_pace_sel`=2 uses `tick_timer`. Ticks from a source that is not selected capture nothing.
- R3: With `cfg_clk_mode`=1 one word is captured per active edge of the synchronized request line: the rising edge when `cfg_strobe_fall`=0, the falling edge when it is 1. The word is taken three clock edges after the raw request line changes.
- R4: With `cfg_clk_mode`=2, an active request in `HS_IDLE` captures one word and asserts acknowledge. Acknowledge stays asserted while request stays active and is removed after request goes inactive. Exactly one word is captured per exchange.
- R5: With `cfg_wait_trig`=0, a tick in the first cycle after enable is captured. With `cfg_wait_trig`=1, no capture happens until the synchronized trigger reads active.
- R6: A sample that arrives while the queue is full is dropped and sets `sts_overrun`. The flag stays set until a one-cycle `ovr_clr_wr` pulse. If a set and a clear fall in the same cycle, the set wins.
- R7: A one-cycle `clr_fifo_wr` pulse empties the queue by the next cycle. A clear wins over a capture in the same cycle.
- R8: `pol_req`=1 and `pol_trig`=1 make low the active level of those inputs. `pol_ack`=1 drives `ack_out` low while acknowledge is asserted and high while it is idle.
- R9: The captured word keeps bits [7:0] for `cfg_width`=0, bits [15:0] for `cfg_width`=1, and all 32 bits for `cfg_width` 2 or 3. Higher bits are zero.
- R10: `sts_full` is 1 exactly while the queue holds FIFO_DEPTH words. It drops once a word is popped.
- R11: Clearing `cfg_en` returns the handshake machine to `HS_IDLE`, so `ack_out` is inactive one cycle later even if request is still active.
- R12: Words leave through `rd_data` in capture order. `rd_data` shows the oldest word while `rd_valid`=1, and `pop` removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Capture enable |
| cfg_clk_mode | input | 2 | 0 pacer, 1 strobe, 2 handshake |
| cfg_pace_sel | input | 2 | 0 fast tick, 1 half-rate tick, 2 timer tick |
| cfg_wait_trig | input | 1 | 1 = hold off until trigger is active |
| cfg_width | input | 2 | 0 = 8 bits, 1 = 16 bits, 2/3 = 32 bits |
| cfg_strobe_fall | input | 1 | 1 = capture on the falling request edge |
| pol_req | input | 1 | Request line is active-low |
| pol_ack | input | 1 | Acknowledge line is active-low |
| pol_trig | input | 1 | Trigger line is active-low |
| clr_fifo_wr | input | 1 | Pulse that empties the queue |
| ovr_clr_wr | input | 1 | Pulse that clears the overrun flag |
| tick_fast | input | 1 | Fast pacer tick |
| tick_timer | input | 1 | Timer channel tick |
| ext_data | input | DATA_W | External parallel data |
| ext_req | input | 1 | External request/strobe line |
| ext_trig | input | 1 | External start trigger |
| ack_out | output | 1 | Acknowledge to the external device |
| pop | input | 1 | Remove the oldest queued word |
| rd_data | output | DATA_W | Oldest queued word |
| rd_valid | output | 1 | Queue is not empty |
| sts_full | output | 1 | Queue is full (live) |
| sts_overrun | output | 1 | Sticky flag for lost samples |

## Verification
A wrong run state makes captures appear before the trigger or go missing. This shows at `rd_valid` within one cycle of the tick that should have been ignored or taken. A handshake machine stuck in `HS_ACK` holds `ack_out` active after the request goes inactive, and it is caught within a few cycles of the expected release. A bad divider phase, a bad edge choice or a bad width mask gives a wrong word count or wrong data at the first drain after the sequence. A lost overrun set or a stale full flag shows at the status pins on the cycle after the extra sample.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        RS_OFF   = 2'd0,
        RS_ARMED = 2'd1,
        RS_RUN   = 2'd2
    } run_state_e;

    typedef enum logic {
        HS_IDLE = 1'b0,
        HS_ACK  = 1'b1
    } hs_state_e;

    localparam logic [1:0] MODE_PACER  = 2'd0;
    localparam logic [1:0] MODE_STROBE = 2'd1;
    localparam logic [1:0] MODE_HSHAKE = 2'd2;

    localparam logic [1:0] PACE_FAST  = 2'd0;
    localparam logic [1:0] PACE_HALF  = 2'd1;
endpackage

// File: rtl/pcap_line_cond.sv
module pcap_line_cond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic pol_low,
    output logic act
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [STAGES-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-2:0], raw};
    end

    // polarity correction after the synchronizer
    assign act = sr[STAGES-1] ^ pol_low;
endmodule

// File: rtl/pcap_hs_fsm.sv
module pcap_hs_fsm
    import pcap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic req_lvl,
    output logic take,
    output logic ack_act
);
    timeunit 1ns;
    timeprecision 1ps;

    hs_state_e st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= HS_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            HS_IDLE: if (active && req_lvl)   st_nx = HS_ACK;
            HS_ACK:  if (!active || !req_lvl) st_nx = HS_IDLE;
            default: st_nx = HS_IDLE;
        endcase
    end

    always_comb begin
        take    = (st == HS_IDLE) && active && req_lvl;
        ack_act = (st == HS_ACK);
    end
endmodule

// File: rtl/pcap_fifo.sv
module pcap_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          full
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = AW + 1;

    logic [DW-1:0]    mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CNT_W-1:0] cnt;
    logic             do_push, do_pop;

    assign full    = (cnt == CNT_W'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end
endmodule

// File: rtl/pcap_ctrl.sv
module pcap_ctrl
    import pcap_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int FIFO_DEPTH  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic [1:0]        cfg_clk_mode,
    input  logic [1:0]        cfg_pace_sel,
    input  logic              cfg_wait_trig,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_strobe_fall,
    input  logic              pol_req,
    input  logic              pol_ack,
    input  logic              pol_trig,
    input  logic              clr_fifo_wr,
    input  logic              ovr_clr_wr,
    input  logic              tick_fast,
    input  logic              tick_timer,
    input  logic [DATA_W-1:0] ext_data,
    input  logic              ext_req,
    input  logic              ext_trig,
    output logic              ack_out,
    input  logic              pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              sts_full,
    output logic              sts_overrun
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N_LINES = 2;   // index 0 request, index 1 trigger

    run_state_e        run_st, run_nx;
    logic [N_LINES-1:0] line_raw, line_pol, line_act;
    logic              req_lvl, trig_lvl;
    logic              req_prev, edge_arm;
    logic              req_rise, req_fall;
    logic              half_ph, pace_hit;
    logic              running, hs_active, hs_take, ack_act;
    logic              smp, fifo_empty, fifo_full;
    logic              ovr_q;
    logic [DATA_W-1:0] cap_word;

    // input conditioning, one synchronizer per external control line
    assign line_raw = {ext_trig, ext_req};
    assign line_pol = {pol_trig, pol_req};

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        pcap_line_cond #(.STAGES(SYNC_STAGES)) u_cond (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw     (line_raw[i]),
            .pol_low (line_pol[i]),
            .act     (line_act[i])
        );
    end

    assign req_lvl  = line_act[0];
    assign trig_lvl = line_act[1];

    // edge detection on the synchronized, polarity-corrected request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_prev <= 1'b0;
            edge_arm <= 1'b0;
        end else begin
            req_prev <= req_lvl;
            edge_arm <= 1'b1;
        end
    end

    assign req_rise = edge_arm && req_lvl && !req_prev;
    assign req_fall = edge_arm && !req_lvl && req_prev;

    // run-control state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_st <= RS_OFF;
        else        run_st <= run_nx;
    end

    always_comb begin
        run_nx = run_st;
        unique case (run_st)
            RS_OFF:   if (cfg_en) run_nx = cfg_wait_trig ? RS_ARMED : RS_RUN;
            RS_ARMED: if (!cfg_en) run_nx = RS_OFF;
                      else if (trig_lvl) run_nx = RS_RUN;
            RS_RUN:   if (!cfg_en) run_nx = RS_OFF;
            default:  run_nx = RS_OFF;
        endcase
    end

    // half-rate phase restarts at each entry into RS_RUN
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  half_ph <= 1'b0;
        else if (run_st != RS_RUN)   half_ph <= 1'b0;
        else if (tick_fast)          half_ph <= ~half_ph;
    end

    always_comb begin
        unique case (cfg_pace_sel)
            PACE_FAST: pace_hit = tick_fast;
            PACE_HALF: pace_hit = tick_fast && half_ph;
            default:   pace_hit = tick_timer;
        endcase
    end

    // output/decision process for the run-control machine
    always_comb begin
        running   = (run_st == RS_RUN) && cfg_en;
        hs_active = running && (cfg_clk_mode == MODE_HSHAKE);
        smp       = 1'b0;
        if (running) begin
            unique case (cfg_clk_mode)
                MODE_PACER:  smp = pace_hit;
                MODE_STROBE: smp = cfg_strobe_fall ? req_fall : req_rise;
                MODE_HSHAKE: smp = hs_take;
                default:     smp = 1'b0;
            endcase
        end
    end

    pcap_hs_fsm u_hs (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (hs_active),
        .req_lvl (req_lvl),
        .take    (hs_take),
        .ack_act (ack_act)
    );

    assign ack_out = ack_act ^ pol_ack;

    // width masking of the captured word
    for (genvar b = 0; b < DATA_W; b++) begin : g_mask
        if (b < 8) begin : g_b8
            assign cap_word[b] = ext_data[b];
        end else if (b < 16) begin : g_b16
            assign cap_word[b] = ext_data[b] && (cfg_width != 2'b00);
        end else begin : g_b32
            assign cap_word[b] = ext_data[b] && cfg_width[1];
        end
    end

    pcap_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_fifo_wr),
        .push  (smp),
        .din   (cap_word),
        .pop   (pop),
        .dout  (rd_data),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    // sticky overrun: set wins over the write-one clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  ovr_q <= 1'b0;
        else if (smp && fifo_full)   ovr_q <= 1'b1;
        else if (ovr_clr_wr)         ovr_q <= 1'b0;
    end

    assign rd_valid    = !fifo_empty;
    assign sts_full    = fifo_full;
    assign sts_overrun = ovr_q;
endmodule

// File: rtl/pcap_chk.sv
module pcap_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_en,
    input logic [1:0] cfg_clk_mode,
    input logic       clr_fifo_wr,
    input logic       ovr_clr_wr,
    input logic       sts_overrun,
    input logic       sts_full,
    input logic       rd_valid,
    input logic       smp,
    input logic       hs_ack,
    input logic       req_lvl
);
    timeunit 1ns;
    timeprecision 1ps;

    // R6
    ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_overrun && !ovr_clr_wr |=> sts_overrun);

    // R6
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp && sts_full |=> sts_overrun);

    // R6
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_clr_wr && !(smp && sts_full) |=> !sts_overrun);

    // R7
    fifo_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fifo_wr |=> !rd_valid);

    // R10
    full_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_full |-> rd_valid);

    // R4
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_ack && req_lvl && cfg_en && (cfg_clk_mode == 2'd2) |=> hs_ack);

    // R4
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_ack && !req_lvl |=> !hs_ack);

    // R11
    dis_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !hs_ack);
endmodule

bind pcap_ctrl pcap_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_en       (cfg_en),
    .cfg_clk_mode (cfg_clk_mode),
    .clr_fifo_wr  (clr_fifo_wr),
    .ovr_clr_wr   (ovr_clr_wr),
    .sts_overrun  (sts_overrun),
    .sts_full     (sts_full),
    .rd_valid     (rd_valid),
    .smp          (smp),
    .hs_ack       (ack_act),
    .req_lvl      (req_lvl)
);

// File: tb/tb_pcap_ctrl.sv
module tb_pcap_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_en, cfg_wait_trig, cfg_strobe_fall;
    logic [1:0]  cfg_clk_mode, cfg_pace_sel, cfg_width;
    logic        pol_req, pol_ack, pol_trig;
    logic        clr_fifo_wr, ovr_clr_wr, tick_fast, tick_timer;
    logic [31:0] ext_data;
    logic        ext_req, ext_trig, ack_out, pop;
    logic [31:0] rd_data;
    logic        rd_valid, sts_full, sts_overrun;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic [31:0] expq [$];

    always #2 clk = ~clk;   // 250 MHz

    pcap_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_clk_mode(cfg_clk_mode),
        .cfg_pace_sel(cfg_pace_sel), .cfg_wait_trig(cfg_wait_trig), .cfg_width(cfg_width),
        .cfg_strobe_fall(cfg_strobe_fall), .pol_req(pol_req), .pol_ack(pol_ack),
        .pol_trig(pol_trig), .clr_fifo_wr(clr_fifo_wr), .ovr_clr_wr(ovr_clr_wr),
        .tick_fast(tick_fast), .tick_timer(tick_timer), .ext_data(ext_data),
        .ext_req(ext_req), .ext_trig(ext_trig), .ack_out(ack_out), .pop(pop),
        .rd_data(rd_data), .rd_valid(rd_valid), .sts_full(sts_full),
        .sts_overrun(sts_overrun)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] wmask(input logic [1:0] w);
        case (w)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one pacer tick with fresh data; keep=1 when the tick should be captured
    task automatic pace(input bit use_timer, input bit keep);
        logic [31:0] d;
        d = $urandom;
        @(negedge clk);
        ext_data = d;
        if (use_timer) tick_timer = 1'b1; else tick_fast = 1'b1;
        @(negedge clk);
        tick_timer = 1'b0;
        tick_fast  = 1'b0;
        if (keep) expq.push_back(d & wmask(cfg_width));
    endtask

    task automatic strobe_word();
        logic [31:0] d;
        d = $urandom;
        @(negedge clk);
        ext_data = d;
        ext_req  = ~pol_req;
        cyc(5);
        ext_req  = pol_req;
        cyc(5);
        expq.push_back(d & wmask(cfg_width));
    endtask

    task automatic hs_word();
        logic [31:0] d;
        logic        on_lvl, off_lvl;
        int          w;
        d       = $urandom;
        on_lvl  = ~pol_ack;
        off_lvl = pol_ack;
        @(negedge clk);
        ext_data = d;
        ext_req  = ~pol_req;
        w = 0;
        while (ack_out !== on_lvl && w < 12) begin @(negedge clk); w++; end
        chk("R4 ack asserted after request", {31'b0, ack_out}, {31'b0, on_lvl});
        cyc(4);
        chk("R4 ack held while request active", {31'b0, ack_out}, {31'b0, on_lvl});
        ext_req = pol_req;
        w = 0;
        while (ack_out !== off_lvl && w < 12) begin @(negedge clk); w++; end
        chk("R4 ack released after request drop", {31'b0, ack_out}, {31'b0, off_lvl});
        cyc(1);
        expq.push_back(d & wmask(cfg_width));
    endtask

    // R12: drain in order and compare against the bench model
    task automatic drain(input string tag);
        while (expq.size() > 0) begin
            logic [31:0] e;
            e = expq.pop_front();
            chk({tag, " R12 valid"}, {31'b0, rd_valid}, 32'd1);
            chk({tag, " R12 data"}, rd_data, e);
            pop = 1'b1;
            @(negedge clk);
            pop = 1'b0;
        end
        chk({tag, " R12 empty after drain"}, {31'b0, rd_valid}, 32'd0);
    endtask

    task automatic run_on();  cfg_en = 1'b1; endtask
    task automatic run_off(); cfg_en = 1'b0; cyc(2); endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        void'($urandom(32'h1234_5678));
        rst_n = 1'b0; cfg_en = 0; cfg_clk_mode = 0; cfg_pace_sel = 0; cfg_wait_trig = 0;
        cfg_width = 2'd2; cfg_strobe_fall = 0; pol_req = 0; pol_ack = 0; pol_trig = 0;
        clr_fifo_wr = 0; ovr_clr_wr = 0; tick_fast = 0; tick_timer = 0; ext_data = 0;
        ext_req = 0; ext_trig = 0; pop = 0;
        cyc(4);
        rst_n = 1'b1;
        cyc(3);

        // R1 reset state
        chk("R1 rd_valid", {31'b0, rd_valid}, 32'd0);
        chk("R1 sts_full", {31'b0, sts_full}, 32'd0);
        chk("R1 sts_overrun", {31'b0, sts_overrun}, 32'd0);
        chk("R1 ack idle", {31'b0, ack_out}, 32'd0);

        // R2 fast tick, R5 immediate start: first tick right after enable
        run_on();
        repeat (4) pace(0, 1);
        repeat (2) pace(1, 0);
        run_off();
        drain("R2 fast / R5 immediate");

        // R2 half-rate
        cfg_pace_sel = 2'd1;
        run_on();
        for (int k = 1; k <= 6; k++) pace(0, (k % 2) == 0);
        run_off();
        drain("R2 half-rate");

        // R2 timer
        cfg_pace_sel = 2'd2;
        run_on();
        repeat (3) pace(1, 1);
        repeat (2) pace(0, 0);
        run_off();
        drain("R2 timer");

        // R9 width masking
        cfg_pace_sel = 2'd0;
        for (int w = 0; w < 3; w++) begin
            cfg_width = w[1:0];
            run_on();
            repeat (3) pace(0, 1);
            run_off();
            drain("R9 width");
        end

        // R3 strobe rising and falling
        cfg_clk_mode = 2'd1;
        for (int f = 0; f < 2; f++) begin
            cfg_strobe_fall = f[0];
            run_on();
            cyc(1);
            repeat (3) strobe_word();
            run_off();
            drain("R3 strobe edge");
        end

        // R8 request polarity (active-low, rising active edge)
        cfg_strobe_fall = 0;
        pol_req = 1'b1; ext_req = 1'b1;
        cyc(4);
        run_on(); cyc(1);
        repeat (3) strobe_word();
        run_off();
        drain("R8 request polarity");
        pol_req = 1'b0; ext_req = 1'b0;
        cyc(4);

        // R4 handshake
        cfg_clk_mode = 2'd2;
        run_on(); cyc(2);
        repeat (4) hs_word();
        run_off();
        drain("R4 handshake");

        // R8 acknowledge and request polarity in handshake
        pol_ack = 1'b1; pol_req = 1'b1; ext_req = 1'b1;
        cyc(4);
        chk("R8 ack idle level high", {31'b0, ack_out}, 32'd1);
        run_on(); cyc(2);
        repeat (2) hs_word();
        run_off();
        drain("R8 handshake polarity");
        pol_ack = 1'b0; pol_req = 1'b0; ext_req = 1'b0;
        cyc(4);

        // R11 disable during an exchange
        begin
            logic [31:0] d;
            int w;
            d = $urandom;
            run_on(); cyc(2);
            ext_data = d; ext_req = 1'b1;
            w = 0;
            while (ack_out !== 1'b1 && w < 12) begin @(negedge clk); w++; end
            chk("R11 ack before disable", {31'b0, ack_out}, 32'd1);
            cfg_en = 1'b0;
            @(negedge clk);
            chk("R11 ack released on disable", {31'b0, ack_out}, 32'd0);
            cyc(3);
            chk("R11 ack stays off with request held", {31'b0, ack_out}, 32'd0);
            ext_req = 1'b0;
            cyc(4);
            expq.push_back(d);
            drain("R11 single word");
        end

        // R5 wait for trigger
        cfg_clk_mode = 2'd0; cfg_wait_trig = 1'b1;
        run_on(); cyc(2);
        repeat (3) pace(0, 0);
        chk("R5 no capture before trigger", {31'b0, rd_valid}, 32'd0);
        ext_trig = 1'b1;
        cyc(4);
        repeat (2) pace(0, 1);
        run_off();
        ext_trig = 1'b0; cfg_wait_trig = 1'b0;
        drain("R5 after trigger");

        // R6 / R10 overrun and full
        run_on();
        for (int i = 0; i < DEPTH; i++) begin
            pace(0, 1);
            if (i == DEPTH - 2) chk("R10 not full one short", {31'b0, sts_full}, 32'd0);
        end
        chk("R10 full at depth", {31'b0, sts_full}, 32'd1);
        pace(0, 0);
        chk("R6 overrun set", {31'b0, sts_overrun}, 32'd1);
        cyc(5);
        chk("R6 overrun sticky", {31'b0, sts_overrun}, 32'd1);
        ovr_clr_wr = 1'b1;
        @(negedge clk);
        ovr_clr_wr = 1'b0;
        chk("R6 overrun cleared", {31'b0, sts_overrun}, 32'd0);
        run_off();
        drain("R6 lost word absent");
        chk("R10 full dropped", {31'b0, sts_full}, 32'd0);

        // R7 queue clear
        run_on();
        repeat (3) pace(0, 0);
        chk("R7 words present before clear", {31'b0, rd_valid}, 32'd1);
        clr_fifo_wr = 1'b1;
        @(negedge clk);
        clr_fifo_wr = 1'b0;
        chk("R7 empty after clear", {31'b0, rd_valid}, 32'd0);
        run_off();
        drain("R7 clear");

        // R2 / R9 / R12 constrained random pacer runs
        for (int it = 0; it < 12; it++) begin
            int sel, cnt, n;
            sel = $urandom_range(0, 2);
            cfg_pace_sel = sel[1:0];
            cfg_width = 2'($urandom_range(0, 3));
            cnt = 0;
            n = $urandom_range(1, 6);
            run_on();
            for (int j = 0; j < n; j++) begin
                if (sel == 2) begin
                    if ($urandom_range(0, 1) == 1) pace(1, 1); else pace(0, 0);
                end else begin
                    cnt++;
                    pace(0, (sel == 0) || (cnt % 2 == 0));
                end
                cyc($urandom_range(0, 3));
            end
            run_off();
            drain("R2 random");
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            summary();
            $finish;
        end
    end
endmodule